// File: doc/BRIEF.md
# Critical-Path Transition Screen for an 8x8 Carry-Save Multiplier

This block is a streaming bit-level model of an unsigned carry-save array multiplier. It does not produce a product. It steps through a fixed sequence of operand pairs. For each new pair it recomputes the sum and carry of every adder cell, compares the cells that feed the final ripple row against their values for the previous pair, and decides whether the transition could drive the slowest path of the array. A qualifying path runs down through the carry-save rows and then left along the whole final row. Each transition that qualifies is sent out as one 32-bit record holding the old and new operands. A timing flow can then replay only these transitions instead of the full space.

The operand pairs come from a built-in counter plus a phase bit, so every step alternates between the low and high halves of the counter. The counter's start and end values are parameters, so a short window can be screened as well as the full range. The record port is a valid/ready pair, and the model stalls while a record waits. A running count of qualifying transitions and a sticky completion flag are also output.

Top module: `critpath_filter`

## Requirements
- R1: While reset is low and on the first cycle after it, rec_valid and done are 0 and match_count is 0. The stored previous operands and the stored previous cell outputs start at zero.
- R2: The counter starts at CNT_FIRST in the low phase. In the low phase the counter first increments, and the pair is x = new counter bits 7:0 and y = bits 15:8. In the high phase the counter holds, and the pair is x = bits 31:24... more precisely x = bits 23:16 and y = bits 31:24. The phase flips after every evaluated pair.
- R3: There are seven rows of eight cells, columns c = 0..7, with partial product p(i,j) = x[j] & y[i]. Each cell computes sum = a^b^ci and carry = majority(a,b,ci). Row 0 takes a = p(0,c+1) (0 at c=7), b = p(1,c) and ci = p(2,c-1) (0 at c=0). Rows r = 1..5 take a = the sum of row r-1 column c+1 (p(r+1,7) at c=7), b = the carry of row r-1 column c, and ci = p(r+2,c-1) (0 at c=0). Final row 6 takes a = the sum of row 5 column c+1 (p(7,7) at c=7), b = the carry of row 5 column c, and ci = the carry of row 6 column c-1 (0 at c=0).
- R4: A cell output has toggled when its value for the current pair differs from its value for the previous pair.
- R5: A transition qualifies when all of the following hold. The final-row cell at column 7 toggles its sum or its carry. None of the final-row cells at columns 1..6 toggles its sum. For an entry column e equal to 0 or 1, the final-row carries at columns e..6 all toggle, and the row-5 sum at column e+1 or the row-5 carry at column e toggles.
- R6: Each qualifying transition produces exactly one record, in sequence order: rec_data[31:24] = previous x, [23:16] = previous y, [15:8] = current x, [7:0] = current y.
- R7: While rec_valid is 1 and rec_ready is 0, no new pair is evaluated and rec_valid and rec_data hold. rec_valid falls only after a cycle in which rec_ready was 1.
- R8: match_count rises by exactly one for each qualifying transition, in the same cycle that its record becomes valid.
- R9: The sequence ends after the high-phase pair for counter value CNT_LAST. After that, done rises once no record is pending and stays high, and no further record appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rec_ready | input | 1 | Consumer accepts the current record |
| rec_valid | output | 1 | A qualifying record is present |
| rec_data | output | 4*OP_W | Previous x, previous y, current x, current y (high to low) |
| match_count | output | MCW | Number of qualifying transitions so far |
| done | output | 1 | Sticky: the sequence has ended and all records are delivered |

## Verification
The bench screens a window of about sixteen thousand operand pairs. In this window the high-half operands are large and fixed, and the low half sweeps a band of y values over every x. The transitions therefore alternate between a swept pair and a pair with long carry chains, which separates real leftward ripples from sums that change early. An independent behavioural walk of all 56 cells produces the expected record stream, so any wrong cell wiring, toggle test or entry-column choice shows up as a missing or extra record. A randomised ready pattern with one long stall tests that records hold and that the sequence pauses. The end of the window tests the final count and the completion flag.

// File: rtl/ctf_pkg.sv
package ctf_pkg;

   typedef enum logic {
      PH_LOW  = 1'b0,
      PH_HIGH = 1'b1
   } ctf_phase_e;

   function automatic logic maj3(input logic a, input logic b, input logic c);
      return (a & b) | (a & c) | (b & c);
   endfunction

endpackage

// File: rtl/ctf_opgen.sv
module ctf_opgen
   import ctf_pkg::*;
#(
   parameter int          N     = 8,
   parameter logic [63:0] FIRST = 64'h0,
   parameter logic [63:0] LAST  = 64'hFFFF_FFFF
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         adv_i,
   output logic [N-1:0] x_o,
   output logic [N-1:0] y_o,
   output logic         last_o
);
   localparam int             CW      = 4 * N;
   localparam logic [CW-1:0]  FIRST_C = FIRST[CW-1:0];
   localparam logic [CW-1:0]  LAST_C  = LAST[CW-1:0];
   localparam logic [CW-1:0]  ONE_C   = {{(CW-1){1'b0}}, 1'b1};

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] inc;
   ctf_phase_e    ph_q;

   assign inc = cnt_q + ONE_C;

   always_comb begin
      if (ph_q == PH_LOW) begin
         x_o = inc[N-1:0];
         y_o = inc[2*N-1:N];
      end else begin
         x_o = cnt_q[3*N-1:2*N];
         y_o = cnt_q[4*N-1:3*N];
      end
   end

   assign last_o = (ph_q == PH_HIGH) && (cnt_q == LAST_C);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= FIRST_C;
         ph_q  <= PH_LOW;
      end else if (adv_i) begin
         if (ph_q == PH_LOW) begin
            cnt_q <= inc;
            ph_q  <= PH_HIGH;
         end else begin
            ph_q  <= PH_LOW;
         end
      end
   end
endmodule

// File: rtl/ctf_array.sv
module ctf_array
   import ctf_pkg::*;
#(
   parameter int N = 8
) (
   input  logic [N-1:0] x_i,
   input  logic [N-1:0] y_i,
   output logic [N-1:1] fs_o,
   output logic [N-1:0] fc_o,
   output logic [2:1]   ds_o,
   output logic [1:0]   dc_o
);
   localparam int SAVE = N - 2;

   logic [SAVE-1:0][N-1:1] ss;
   logic [SAVE-1:0][N-1:0] sc;
   logic [N-1:1]           fs;
   logic [N-1:0]           fc;

   function automatic logic pb(input logic [N-1:0] xv, input logic [N-1:0] yv,
                               input int i, input int j);
      return xv[j] & yv[i];
   endfunction

   always_comb begin
      logic a, b, ci;
      ss = '0;
      sc = '0;
      fs = '0;
      fc = '0;
      // first carry-save row: three partial-product rows
      sc[0][0] = pb(x_i, y_i, 0, 1) & pb(x_i, y_i, 1, 0);
      for (int c = 1; c < N-1; c++) begin
         a  = pb(x_i, y_i, 0, c+1);
         b  = pb(x_i, y_i, 1, c);
         ci = pb(x_i, y_i, 2, c-1);
         ss[0][c] = a ^ b ^ ci;
         sc[0][c] = maj3(a, b, ci);
      end
      a  = 1'b0;
      b  = pb(x_i, y_i, 1, N-1);
      ci = pb(x_i, y_i, 2, N-2);
      ss[0][N-1] = a ^ b ^ ci;
      sc[0][N-1] = maj3(a, b, ci);
      // remaining carry-save rows
      for (int r = 1; r < SAVE; r++) begin
         sc[r][0] = ss[r-1][1] & sc[r-1][0];
         for (int c = 1; c < N-1; c++) begin
            a  = ss[r-1][c+1];
            b  = sc[r-1][c];
            ci = pb(x_i, y_i, r+2, c-1);
            ss[r][c] = a ^ b ^ ci;
            sc[r][c] = maj3(a, b, ci);
         end
         a  = pb(x_i, y_i, r+1, N-1);
         b  = sc[r-1][N-1];
         ci = pb(x_i, y_i, r+2, N-2);
         ss[r][N-1] = a ^ b ^ ci;
         sc[r][N-1] = maj3(a, b, ci);
      end
      // final ripple row
      fc[0] = ss[SAVE-1][1] & sc[SAVE-1][0];
      for (int c = 1; c < N-1; c++) begin
         a  = ss[SAVE-1][c+1];
         b  = sc[SAVE-1][c];
         ci = fc[c-1];
         fs[c] = a ^ b ^ ci;
         fc[c] = maj3(a, b, ci);
      end
      a  = pb(x_i, y_i, N-1, N-1);
      b  = sc[SAVE-1][N-1];
      ci = fc[N-2];
      fs[N-1] = a ^ b ^ ci;
      fc[N-1] = maj3(a, b, ci);
   end

   assign fs_o = fs;
   assign fc_o = fc;
   assign ds_o = ss[SAVE-1][2:1];
   assign dc_o = sc[SAVE-1][1:0];
endmodule

// File: rtl/ctf_pathchk.sv
module ctf_pathchk #(
   parameter int N = 8
) (
   input  logic [N-1:1] tfs_i,
   input  logic [N-1:0] tfc_i,
   input  logic [2:1]   tds_i,
   input  logic [1:0]   tdc_i,
   output logic         hit_o
);
   logic [1:0] ep;

   for (genvar e = 0; e < 2; e++) begin : g_entry
      assign ep[e] = (&tfc_i[N-2:e]) & (tds_i[e+1] | tdc_i[e]);
   end

   assign hit_o = (|ep) & ~(|tfs_i[N-2:1]) & (tfs_i[N-1] | tfc_i[N-1]);
endmodule

// File: rtl/critpath_filter.sv
module critpath_filter #(
   parameter int          OP_W      = 8,
   parameter logic [63:0] CNT_FIRST = 64'h0,
   parameter logic [63:0] CNT_LAST  = 64'hFFFF_FFFF,
   parameter int          MCW       = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rec_ready,
   output logic              rec_valid,
   output logic [4*OP_W-1:0] rec_data,
   output logic [MCW-1:0]    match_count,
   output logic              done
);
   localparam int             CW    = 4 * OP_W;
   localparam logic [MCW-1:0] M_ONE = {{(MCW-1){1'b0}}, 1'b1};

   if (OP_W < 4) begin : g_bad_width
      $error("critpath_filter: OP_W must be at least 4");
   end
   if (CNT_FIRST >= CNT_LAST) begin : g_bad_range
      $error("critpath_filter: CNT_FIRST must be below CNT_LAST");
   end
   if ((CNT_LAST >> CW) != 64'h0) begin : g_bad_last
      $error("critpath_filter: CNT_LAST exceeds the counter width");
   end

   logic [OP_W-1:0] gx, gy;
   logic            g_last;
   logic            step;
   logic [OP_W-1:1] cur_fs, prv_fs;
   logic [OP_W-1:0] cur_fc, prv_fc;
   logic [2:1]      cur_ds, prv_ds;
   logic [1:0]      cur_dc, prv_dc;
   logic [OP_W-1:0] prv_x, prv_y;
   logic            hit;
   logic            vld_q, fin_q;
   logic [CW-1:0]   data_q;
   logic [MCW-1:0]  mcnt_q;

   assign step = !fin_q && (!vld_q || rec_ready);

   ctf_opgen #(.N(OP_W), .FIRST(CNT_FIRST), .LAST(CNT_LAST)) u_gen (
      .clk    (clk),
      .rst_n  (rst_n),
      .adv_i  (step),
      .x_o    (gx),
      .y_o    (gy),
      .last_o (g_last)
   );

   ctf_array #(.N(OP_W)) u_arr (
      .x_i  (gx),
      .y_i  (gy),
      .fs_o (cur_fs),
      .fc_o (cur_fc),
      .ds_o (cur_ds),
      .dc_o (cur_dc)
   );

   ctf_pathchk #(.N(OP_W)) u_chk (
      .tfs_i (cur_fs ^ prv_fs),
      .tfc_i (cur_fc ^ prv_fc),
      .tds_i (cur_ds ^ prv_ds),
      .tdc_i (cur_dc ^ prv_dc),
      .hit_o (hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prv_x  <= '0;
         prv_y  <= '0;
         prv_fs <= '0;
         prv_fc <= '0;
         prv_ds <= '0;
         prv_dc <= '0;
         vld_q  <= 1'b0;
         fin_q  <= 1'b0;
         data_q <= '0;
         mcnt_q <= '0;
      end else begin
         if (vld_q && rec_ready) begin
            vld_q <= 1'b0;
         end
         if (step) begin
            prv_x  <= gx;
            prv_y  <= gy;
            prv_fs <= cur_fs;
            prv_fc <= cur_fc;
            prv_ds <= cur_ds;
            prv_dc <= cur_dc;
            fin_q  <= g_last;
            if (hit) begin
               vld_q  <= 1'b1;
               data_q <= {prv_x, prv_y, gx, gy};
               mcnt_q <= mcnt_q + M_ONE;
            end
         end
      end
   end

   assign rec_valid   = vld_q;
   assign rec_data    = data_q;
   assign match_count = mcnt_q;
   assign done        = fin_q && !vld_q;
endmodule

// File: rtl/ctf_checker.sv
module ctf_checker #(
   parameter int DW  = 32,
   parameter int MCW = 32
) (
   input logic           clk,
   input logic           rst_n,
   input logic           rec_ready,
   input logic           rec_valid,
   input logic [DW-1:0]  rec_data,
   input logic [MCW-1:0] match_count,
   input logic           done
);
   localparam logic [MCW-1:0] ONE_C = {{(MCW-1){1'b0}}, 1'b1};

   assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!rec_valid && !done && match_count == '0));

   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_valid && !rec_ready) |=> (rec_valid && $stable(rec_data)));

   assert_drop_after_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rec_valid) |-> $past(rec_ready));

   assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (match_count != $past(match_count)) |->
         ((match_count - $past(match_count)) == ONE_C && rec_valid));

   assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done);

   assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !rec_valid);
endmodule

bind critpath_filter ctf_checker #(.DW(4*OP_W), .MCW(MCW)) u_ctf_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .rec_ready   (rec_ready),
   .rec_valid   (rec_valid),
   .rec_data    (rec_data),
   .match_count (match_count),
   .done        (done)
);

// File: tb/test_critpath_filter.sv
module test_critpath_filter;
   localparam logic [63:0] FIRST = 64'hE9D3_9800;
   localparam logic [63:0] LAST  = 64'hE9D3_B800;

   logic        clk       = 1'b0;
   logic        rst_n     = 1'b0;
   logic        rec_ready = 1'b0;
   logic        rec_valid;
   logic [31:0] rec_data;
   logic [31:0] match_count;
   logic        done;

   always #2 clk = ~clk;

   critpath_filter #(
      .OP_W(8), .CNT_FIRST(FIRST), .CNT_LAST(LAST), .MCW(32)
   ) i_critpath_filter (
      .clk         (clk),
      .rst_n       (rst_n),
      .rec_ready   (rec_ready),
      .rec_valid   (rec_valid),
      .rec_data    (rec_data),
      .match_count (match_count),
      .done        (done)
   );

   int          n_run = 0;
   int          n_fail = 0;
   int          exp_total = 0;
   int          got_total = 0;
   logic [31:0] exp_q[$];
   bit          cs[7][8];
   bit          ck[7][8];
   bit          ls[7][8];
   bit          lk[7][8];
   logic [7:0]  lx = 8'h0;
   logic [7:0]  ly = 8'h0;

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic int pbit(input logic [7:0] x, input logic [7:0] y,
                               input int i, input int j);
      return (x[j] && y[i]) ? 1 : 0;
   endfunction

   // behavioural walk of all cells (R3)
   task automatic eval_cells(input logic [7:0] x, input logic [7:0] y);
      for (int r = 0; r < 7; r++) begin
         for (int c = 0; c < 8; c++) begin
            int a, b, ci, t;
            if (r == 0) begin
               a  = (c < 7) ? pbit(x, y, 0, c+1) : 0;
               b  = pbit(x, y, 1, c);
               ci = (c > 0) ? pbit(x, y, 2, c-1) : 0;
            end else if (r < 6) begin
               a  = (c < 7) ? int'(cs[r-1][c+1]) : pbit(x, y, r+1, 7);
               b  = int'(ck[r-1][c]);
               ci = (c > 0) ? pbit(x, y, r+2, c-1) : 0;
            end else begin
               a  = (c < 7) ? int'(cs[5][c+1]) : pbit(x, y, 7, 7);
               b  = int'(ck[5][c]);
               ci = (c > 0) ? int'(ck[6][c-1]) : 0;
            end
            t = a + b + ci;
            cs[r][c] = (t % 2) == 1;
            ck[r][c] = t >= 2;
         end
      end
   endtask

   // leftward walk along the final row (R4, R5)
   function automatic bit qualifies();
      int c;
      if (!((cs[6][7] != ls[6][7]) || (ck[6][7] != lk[6][7]))) return 1'b0;
      for (int k = 1; k < 7; k++) begin
         if (cs[6][k] != ls[6][k]) return 1'b0;
      end
      c = 6;
      while (c >= 0 && (ck[6][c] != lk[6][c])) begin
         if (c <= 1 && ((cs[5][c+1] != ls[5][c+1]) || (ck[5][c] != lk[5][c])))
            return 1'b1;
         c--;
      end
      return 1'b0;
   endfunction

   task automatic step_pair(input logic [7:0] x, input logic [7:0] y);
      eval_cells(x, y);
      if (qualifies()) begin
         exp_q.push_back({lx, ly, x, y});
         exp_total++;
      end
      ls = cs;
      lk = ck;
      lx = x;
      ly = y;
   endtask

   // driver: builds the expected record stream from the operand sequence (R2)
   task automatic build_expect();
      logic [31:0] cnt;
      for (int r = 0; r < 7; r++) begin
         for (int c = 0; c < 8; c++) begin
            ls[r][c] = 1'b0;
            lk[r][c] = 1'b0;
         end
      end
      cnt = FIRST[31:0];
      do begin
         cnt = cnt + 32'd1;
         step_pair(cnt[7:0], cnt[15:8]);
         step_pair(cnt[23:16], cnt[31:24]);
      end while (cnt != LAST[31:0]);
   endtask

   // ready pattern: pseudo-random with one long stall
   initial begin
      logic [15:0] lfsr;
      int          cyc;
      lfsr = 16'hACE1;
      cyc  = 0;
      forever begin
         @(posedge clk);
         #1;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         cyc++;
         if (cyc >= 400 && cyc < 460) rec_ready = 1'b0;
         else rec_ready = (lfsr[1:0] != 2'b00);
      end
   end

   // monitor
   bit          hold_prev = 1'b0;
   logic [31:0] data_prev = '0;
   bit          done_seen = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (hold_prev) begin
            check(rec_valid && rec_data == data_prev, "R7 held record",
                  {31'd0, rec_valid, rec_data}, {32'd1, data_prev});
         end
         if (rec_valid && rec_ready) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R6 unexpected record", {32'd0, rec_data}, 64'd0);
            end else begin
               logic [31:0] e;
               e = exp_q.pop_front();
               got_total++;
               check(rec_data == e, "R6 record (R2 R3 R4 R5)", {32'd0, rec_data},
                     {32'd0, e});
            end
         end
         if (done && !done_seen) begin
            done_seen = 1'b1;
            check(exp_q.size() == 0, "R9 done with records left",
                  64'(exp_q.size()), 64'd0);
         end
         hold_prev = rec_valid && !rec_ready;
         data_prev = rec_data;
      end
   end

   initial begin
      int cyc;
      build_expect();
      $display("[TB] expected qualifying transitions: %0d", exp_total);
      rst_n = 1'b0;
      repeat (5) @(posedge clk);
      @(negedge clk);
      check(!rec_valid && !done && match_count == 32'd0, "R1 in reset",
            {31'd0, rec_valid, done, match_count}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!rec_valid && !done && match_count == 32'd0, "R1 after release",
            {31'd0, rec_valid, done, match_count}, 64'd0);
      cyc = 0;
      while (!done && cyc < 150000) begin
         @(negedge clk);
         cyc++;
      end
      check(done == 1'b1, "R9 watchdog: done not reached", {63'd0, done}, 64'd1);
      repeat (20) @(negedge clk);
      check(done == 1'b1, "R9 done sticky", {63'd0, done}, 64'd1);
      check(rec_valid == 1'b0, "R9 no record after end", {63'd0, rec_valid}, 64'd0);
      check(match_count == 32'(exp_total), "R8 match count",
            {32'd0, match_count}, 64'(exp_total));
      check(got_total == exp_total, "R6 record total", 64'(got_total),
            64'(exp_total));
      check(exp_q.size() == 0, "R6 queue drained", 64'(exp_q.size()), 64'd0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule